// File: doc/BRIEF.md
# Fatal Error Event and Halt Controller

This block holds the event register of a serial cell interface and applies the global stop actions that follow a fatal error. It watches the receiver lock status, the carrier sense status (qualified by the DPLL enable), a receive FIFO overrun pulse and a transmit FIFO underrun pulse. Each of these raises a sticky event bit. The host clears event bits by writing ones to them.

A receive overrun or a loss of lock stops reception and memory transfers on every channel. Reception stays stopped until the host issues a restart-receive command. A transmit underrun stops transmission on every channel and sets a disabled status bit, and the line then idles high. Transmission resumes when the host clears the disabled bit. A scheduler that is still active in the same cycle as that clear sets the bit again, so the host has to read the bit back to confirm the clear, waiting at least 50 clocks before it does.

Top module: `fatal_evt_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `events` is zero, `rx_enable` and `tx_enable` are 1, `dis_status` is 0, and `tx_line` equals `tx_bit`.
- R2: A change of `rx_lock` in either direction, sampled at a clock edge, sets bit 1 (sync) of `events` at that edge.
- R3: A change of `cs_status` sets bit 0 (carrier change) of `events` only if `dpll_en` is 1 at that edge. With `dpll_en` at 0 the change leaves `events` unchanged.
- R4: A pulse on `rx_ovr_p` sets bit 2 (receive overrun) of `events` and drives `rx_enable` to 0 at that edge.
- R5: A pulse on `tx_und_p` sets bit 3 (transmit underrun) of `events`, sets `dis_status` to 1 and drives `tx_enable` to 0 at that edge.
- R6: While `dis_status` is 1, `tx_line` is 1. Otherwise `tx_line` equals `tx_bit`.
- R7: A 1-to-0 change of `rx_lock` drives `rx_enable` to 0. `restart_rx` sets `rx_enable` back to 1 at the next edge, unless a loss of lock or an overrun occurs at the same edge, in which case reception stays stopped.
- R8: A write with `host_wr`=1 clears each event bit whose `host_wdata` bit is 1 and leaves the other bits unchanged. An event arriving at the same edge as its clear leaves the bit at 1.
- R9: Bits 4 to 15 of `events` always read 0, even after a write of ones.
- R10: `host_clr_dis` clears `dis_status` and sets `tx_enable` to 1 at the next edge, unless `sched_active` or `tx_und_p` is 1 at the same edge, in which case `dis_status` stays 1.
- R11: Event bits are sticky. With no write, a set bit remains set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_lock | input | 1 | Receiver cell lock status |
| cs_status | input | 1 | Carrier sense status |
| dpll_en | input | 1 | DPLL enable; qualifies carrier change events |
| rx_ovr_p | input | 1 | Receive FIFO overrun pulse |
| tx_und_p | input | 1 | Transmit FIFO underrun pulse |
| tx_bit | input | 1 | Transmit data bit from the serializer |
| host_wr | input | 1 | Host write strobe for the event register |
| host_wdata | input | EV_W | Write-one-to-clear mask |
| restart_rx | input | 1 | Restart-receive command |
| host_clr_dis | input | 1 | Host request to clear the disabled bit |
| sched_active | input | 1 | Scheduler still active; re-sets the disabled bit |
| events | output | EV_W | Sticky event register |
| rx_enable | output | 1 | Receive and memory transfer gate |
| tx_enable | output | 1 | Transmit gate |
| tx_line | output | 1 | Transmit line value |
| dis_status | output | 1 | Transmit disabled status bit |

## Verification
`events`, `rx_enable`, `tx_enable` and `dis_status` are registered, so each one is due at the first rising edge that samples the stimulus. `tx_line` follows `tx_bit` in the same cycle and follows `dis_status` one edge after an underrun or a clear. The bench changes inputs only on falling edges and advances its reference model at the rising edge. It compares every output on the next falling edge, so each result is checked exactly one edge after its cause.

// File: rtl/fatal_evt_pkg.sv
// Package: shared event bit positions and the implemented-bit mask.
// Assumes the event register is at least 4 bits wide.
package fatal_evt_pkg;
    localparam int EVB_CSC  = 0;  // carrier sense change
    localparam int EVB_SYNC = 1;  // lock status change
    localparam int EVB_ROVR = 2;  // receive FIFO overrun
    localparam int EVB_TUND = 3;  // transmit FIFO underrun
    localparam int EV_USED  = 4;

    // Returns a mask with the implemented event bits set.
    function automatic logic [63:0] impl_mask(input int w);
        logic [63:0] m;
        m = '0;
        for (int i = 0; i < EV_USED && i < w; i++) m[i] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/change_det.sv
// Module: registers a vector of level inputs and flags the bits that
// differ from the previous cycle. Assumes inputs are already synchronous.
module change_det #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sig,
    output logic [W-1:0] prev,
    output logic [W-1:0] toggled
);
    // Hold the value sampled at the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= sig;
    end

    // Bitwise difference between current and previous level.
    always_comb toggled = sig ^ prev;

    a_r2_prev_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (prev == $past(sig)));
endmodule

// File: rtl/evt_reg.sv
// Module: sticky event register with write-one-to-clear. Bits outside
// MASK are not stored and read as zero. A set in the same cycle as a
// clear wins.
module evt_reg #(
    parameter int          W    = 16,
    parameter logic [63:0] MASK = 64'hF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sets,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    logic [W-1:0] clr;

    // Clear mask is active only during a host write.
    always_comb clr = wr ? wdata : '0;

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (MASK[i]) begin : g_impl
            // One sticky flop per implemented bit.
            always_ff @(posedge clk) begin
                if (!rst_n)       q[i] <= 1'b0;
                else if (sets[i]) q[i] <= 1'b1;
                else if (clr[i])  q[i] <= 1'b0;
            end
        end else begin : g_resv
            assign q[i] = 1'b0;
        end
    end

    a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> ((q & $past(q)) == $past(q)));
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((q & $past(sets) & MASK[W-1:0]) == ($past(sets) & MASK[W-1:0])));
    a_r9_resv_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (q & ~MASK[W-1:0]) == '0);
endmodule

// File: rtl/halt_ctrl.sv
// Module: global receive stop and transmit disable. Reception stops on a
// fatal receive cause and resumes on restart. The disabled bit is set by
// an underrun and cleared by the host unless the scheduler re-sets it.
module halt_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_fatal,
    input  logic restart_rx,
    input  logic tx_und,
    input  logic clr_dis,
    input  logic sched_active,
    input  logic tx_bit,
    output logic rx_enable,
    output logic tx_enable,
    output logic dis,
    output logic tx_line
);
    logic rx_stopped;

    // Receive stop state: a fatal cause beats a restart.
    always_ff @(posedge clk) begin
        if (!rst_n)          rx_stopped <= 1'b0;
        else if (rx_fatal)   rx_stopped <= 1'b1;
        else if (restart_rx) rx_stopped <= 1'b0;
    end

    // Disabled bit: underrun or active scheduler keeps it set.
    always_ff @(posedge clk) begin
        if (!rst_n)                        dis <= 1'b0;
        else if (tx_und)                   dis <= 1'b1;
        else if (clr_dis && !sched_active) dis <= 1'b0;
    end

    // Gates and idle-high transmit line.
    always_comb begin
        rx_enable = !rx_stopped;
        tx_enable = !dis;
        tx_line   = dis ? 1'b1 : tx_bit;
    end

    a_r7_fatal_stops_rx: assert property (@(posedge clk) disable iff (!rst_n)
        rx_fatal |=> !rx_enable);
    a_r5_und_disables: assert property (@(posedge clk) disable iff (!rst_n)
        tx_und |=> (dis && !tx_enable));
    a_r10_sched_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_dis && sched_active) |=> dis == $past(dis || tx_und));
    a_r6_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        dis |-> tx_line);
endmodule

// File: rtl/fatal_evt_ctrl.sv
// Module: top of the fatal error event and halt controller. Derives
// events from status changes and fault pulses, stores them in the event
// register and drives the global halt logic. Assumes synchronous inputs.
module fatal_evt_ctrl
    import fatal_evt_pkg::*;
#(
    parameter int EV_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rx_lock,
    input  logic            cs_status,
    input  logic            dpll_en,
    input  logic            rx_ovr_p,
    input  logic            tx_und_p,
    input  logic            tx_bit,
    input  logic            host_wr,
    input  logic [EV_W-1:0] host_wdata,
    input  logic            restart_rx,
    input  logic            host_clr_dis,
    input  logic            sched_active,
    output logic [EV_W-1:0] events,
    output logic            rx_enable,
    output logic            tx_enable,
    output logic            tx_line,
    output logic            dis_status
);
    localparam logic [63:0] EV_MASK = impl_mask(EV_W);
    localparam int          LK = 0;
    localparam int          CS = 1;

    logic [1:0]      lvl_prev;
    logic [1:0]      lvl_tog;
    logic [EV_W-1:0] ev_sets;
    logic            lock_lost;

    change_det #(.W(2)) u_chg (
        .clk     (clk),
        .rst_n   (rst_n),
        .sig     ({cs_status, rx_lock}),
        .prev    (lvl_prev),
        .toggled (lvl_tog)
    );

    // Map causes onto event bit positions.
    always_comb begin
        ev_sets           = '0;
        ev_sets[EVB_SYNC] = lvl_tog[LK];
        ev_sets[EVB_CSC]  = lvl_tog[CS] && dpll_en;
        ev_sets[EVB_ROVR] = rx_ovr_p;
        ev_sets[EVB_TUND] = tx_und_p;
        lock_lost         = lvl_prev[LK] && !rx_lock;
    end

    evt_reg #(.W(EV_W), .MASK(EV_MASK)) u_ev (
        .clk   (clk),
        .rst_n (rst_n),
        .sets  (ev_sets),
        .wr    (host_wr),
        .wdata (host_wdata),
        .q     (events)
    );

    halt_ctrl u_halt (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_fatal     (lock_lost || rx_ovr_p),
        .restart_rx   (restart_rx),
        .tx_und       (tx_und_p),
        .clr_dis      (host_clr_dis),
        .sched_active (sched_active),
        .tx_bit       (tx_bit),
        .rx_enable    (rx_enable),
        .tx_enable    (tx_enable),
        .dis          (dis_status),
        .tx_line      (tx_line)
    );

    a_r2_sync_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_lock != lvl_prev[LK]) |=> events[EVB_SYNC]);
    a_r3_csc_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (!dpll_en && !events[EVB_CSC]) |=> !events[EVB_CSC]);
    a_r7_lock_loss_halts: assert property (@(posedge clk) disable iff (!rst_n)
        lock_lost |=> !rx_enable);
endmodule

// File: tb/tb_fatal_evt_ctrl.sv
// Bench: directed corners plus seeded random stimulus against a model.
module tb_fatal_evt_ctrl;
    localparam int CLK_P = 10;
    localparam int EV_W  = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic rx_lock = 0, cs_status = 0, dpll_en = 0, rx_ovr_p = 0, tx_und_p = 0;
    logic tx_bit = 0, host_wr = 0, restart_rx = 0, host_clr_dis = 0, sched_active = 0;
    logic [EV_W-1:0] host_wdata = '0;
    logic [EV_W-1:0] events;
    logic rx_enable, tx_enable, tx_line, dis_status;

    int checks = 0, errs = 0;
    logic [EV_W-1:0] m_ev = '0;
    logic m_rxs = 0, m_dis = 0, m_pl = 0, m_pcs = 0;

    always #(CLK_P/2) clk = ~clk;

    fatal_evt_ctrl #(.EV_W(EV_W)) dut (.*);

    // Reference model of the next event register value.
    function automatic logic [EV_W-1:0] next_ev();
        logic [EV_W-1:0] s;
        s = '0;
        s[1] = (rx_lock != m_pl);
        s[0] = dpll_en && (cs_status != m_pcs);
        s[2] = rx_ovr_p;
        s[3] = tx_und_p;
        return ((m_ev & ~(host_wr ? host_wdata : '0)) | s) & 16'h000F;
    endfunction

    task automatic model_edge();
        logic [EV_W-1:0] e;
        e = next_ev();
        if (rx_ovr_p || (m_pl && !rx_lock)) m_rxs = 1'b1;
        else if (restart_rx)                m_rxs = 1'b0;
        if (tx_und_p)                           m_dis = 1'b1;
        else if (host_clr_dis && !sched_active) m_dis = 1'b0;
        m_ev = e; m_pl = rx_lock; m_pcs = cs_status;
    endtask

    task automatic chk(input string tag, input logic [EV_W-1:0] act, input logic [EV_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic verify(input string tag);
        chk({tag, " events"}, events, m_ev);
        chk({tag, " rx_enable"}, 16'(rx_enable), 16'(!m_rxs));
        chk({tag, " tx_enable"}, 16'(tx_enable), 16'(!m_dis));
        chk({tag, " dis_status"}, 16'(dis_status), 16'(m_dis));
        chk({tag, " R6 tx_line"}, 16'(tx_line), 16'(m_dis ? 1'b1 : tx_bit));
    endtask

    task automatic step(input string tag);
        @(posedge clk); model_edge();
        @(negedge clk);
        verify(tag);
        rx_ovr_p = 0; tx_und_p = 0; host_wr = 0; restart_rx = 0;
        host_clr_dis = 0; sched_active = 0; host_wdata = '0;
    endtask

    initial begin
        #(CLK_P * 150000);
        errs++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state, fixed values
        chk("R1 events", events, 16'h0);
        chk("R1 rx_enable", 16'(rx_enable), 16'd1);
        chk("R1 tx_enable", 16'(tx_enable), 16'd1);
        chk("R1 dis", 16'(dis_status), 16'd0);
        tx_bit = 1; #1; chk("R1 tx_line", 16'(tx_line), 16'd1);
        tx_bit = 0; #1; chk("R6 tx_line follows", 16'(tx_line), 16'd0);
        // R2 gain and loss of lock; R7 loss stops rx
        rx_lock = 1; step("R2 gain");
        chk("R2 sync set on gain", events, 16'h0002);
        host_wr = 1; host_wdata = 16'hFFFF; step("R9 clear all");
        chk("R9 reserved zero", events, 16'h0000);
        rx_lock = 0; step("R2 loss");
        chk("R7 rx stopped", 16'(rx_enable), 16'd0);
        // R7 restart with simultaneous overrun stays stopped
        restart_rx = 1; rx_ovr_p = 1; step("R7 fatal wins");
        chk("R4 overrun bit", events & 16'h0004, 16'h0004);
        chk("R7 still stopped", 16'(rx_enable), 16'd0);
        restart_rx = 1; step("R7 restart");
        chk("R7 resumed", 16'(rx_enable), 16'd1);
        // R3 carrier change gated by dpll_en
        host_wr = 1; host_wdata = 16'h000F; step("R8 clear");
        cs_status = 1; dpll_en = 0; step("R3 gated");
        chk("R3 no event when disabled", events, 16'h0000);
        dpll_en = 1; cs_status = 0; step("R3 enabled");
        chk("R3 event", events, 16'h0001);
        // R8 set beats clear, partial clear
        cs_status = 1; host_wr = 1; host_wdata = 16'h0001; step("R8 set wins");
        chk("R8 set wins", events, 16'h0001);
        rx_ovr_p = 1; step("R11 sticky");
        host_wr = 1; host_wdata = 16'h0001; step("R8 partial");
        chk("R8 partial clear", events, 16'h0004);
        // R5 underrun, R6 idle high, R10 scheduler override
        tx_bit = 0; tx_und_p = 1; step("R5 underrun");
        chk("R5 dis set", 16'(dis_status), 16'd1);
        chk("R6 idle high", 16'(tx_line), 16'd1);
        host_clr_dis = 1; sched_active = 1; step("R10 sched");
        chk("R10 held by scheduler", 16'(dis_status), 16'd1);
        host_clr_dis = 1; tx_und_p = 1; step("R10 und");
        chk("R10 held by underrun", 16'(dis_status), 16'd1);
        host_clr_dis = 1; step("R10 clear");
        chk("R10 cleared", 16'(tx_enable), 16'd1);
        // Random phase
        for (int i = 0; i < 2000; i++) begin
            if ($urandom % 8 == 0) rx_lock = ~rx_lock;
            if ($urandom % 5 == 0) cs_status = ~cs_status;
            dpll_en = 1'($urandom);
            rx_ovr_p = ($urandom % 16 == 0);
            tx_und_p = ($urandom % 16 == 0);
            restart_rx = ($urandom % 6 == 0);
            host_clr_dis = ($urandom % 4 == 0);
            sched_active = 1'($urandom);
            host_wr = ($urandom % 3 == 0);
            host_wdata = 16'($urandom);
            tx_bit = 1'($urandom);
            step("R8 R11 random");
        end
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule